// File: doc/BRIEF.md
# Single-Active Scan Chain Wrapper

This block wraps a small functional core whose state sits in `NUM_FF` scan flip-flops. The flip-flops are cut, in index order, into `NUM_CHAINS` scan chains of `ceil(NUM_FF/NUM_CHAINS)` cells each. The final chain holds whatever cells remain. In normal operation every cell loads the core's next state on each clock.

In test mode only the chain named by `chain_sel` is updated. The update is a shift when `scan_en` is high and a functional capture when it is low. Every other chain keeps its contents. Because one chain at most switches in any test cycle, both the shift phase and the capture cycle draw the current of a single chain. Clock gating is modelled as a synchronous enable per chain on one shared clock.

`scan_out` is a multiplexer that `chain_sel` steers to the tail cell of the addressed chain. A select code with no chain behind it enables nothing and drives `scan_out` low.

Top module: `solo_chain_scan`

## Requirements
- R1: A clock edge with `rst_n` low clears every cell, so afterwards `scan_out` and `func_out` read all zeros.
- R2: With `test_mode` 0, every cell i loads `func_in[i] XOR cell[(i-1) mod NUM_FF]` on each edge, and `scan_en` and `chain_sel` have no effect on the update.
- R3: With `test_mode` 1, `scan_en` 1 and `chain_sel` = k < NUM_CHAINS, the lowest-index cell of chain k takes `scan_in` and each other cell of chain k takes the value of the cell one index below it.
- R4: With `test_mode` 1, `scan_en` 0 and `chain_sel` = k < NUM_CHAINS, each cell of chain k loads the same next-state value as in R2, computed from the state before the edge.
- R5: In test mode, every cell outside the selected chain keeps its value, in both shift and capture.
- R6: `scan_out` equals the highest-index cell of chain `chain_sel` whenever `chain_sel` < NUM_CHAINS, in either mode.
- R7: With `chain_sel` >= NUM_CHAINS, `scan_out` is 0, and in test mode no cell changes.
- R8: Chain k covers cells k*L up to min((k+1)*L, NUM_FF)-1, where L = ceil(NUM_FF/NUM_CHAINS). With the default values 10 and 3 this gives chains of 4, 4 and 2 cells.
- R9: `func_out[i]` equals `cell[i] XOR cell[(i+1) mod NUM_FF]` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock shared by all chains |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 1: only the selected chain updates; 0: all cells run functionally |
| scan_en | input | 1 | In test mode: 1 shifts, 0 captures |
| chain_sel | input | SEL_W | Index of the active chain |
| scan_in | input | 1 | Serial data into the lowest cell of the active chain |
| func_in | input | NUM_FF | Primary inputs of the core |
| scan_out | output | 1 | Tail cell of the addressed chain, or 0 |
| func_out | output | NUM_FF | Primary outputs of the core |

## Verification
A cell wrongly held or wrongly updated changes `func_out` on the very next cycle, because each output bit depends on two adjacent cells. The fault reaches `scan_out` at the latest after one chain length of shifting. A chain boundary in the wrong place shows up as a tail bit appearing one or more shifts early or late. A leak into an unselected chain shows when that chain is unloaded later. The bench drives long mixed sequences of shift, capture, normal and out-of-range cycles against a bit-accurate model, so a wrong cell is compared at most a few cycles after it goes wrong.

// File: rtl/solo_scan_pkg.sv
// Shared sizing helpers for the single-active scan wrapper.
// Assumes at least one cell per chain: NUM_FF > (NUM_CHAINS-1)*ceil(NUM_FF/NUM_CHAINS).
package solo_scan_pkg;

    // Nominal cells per chain: ceiling of flops over chains.
    function automatic int seg_cells(input int nff, input int nch);
        return (nff + nch - 1) / nch;
    endfunction

    // Actual length of chain k; the final chain takes the remainder.
    function automatic int seg_len(input int nff, input int nch, input int k);
        int l;
        int rem;
        l   = seg_cells(nff, nch);
        rem = nff - k * l;
        return (rem < l) ? rem : l;
    endfunction

    // Width of the chain select code.
    function automatic int sel_bits(input int nch);
        return (nch > 1) ? $clog2(nch) : 1;
    endfunction

endpackage

// File: rtl/chain_enable_dec.sv
// Decodes the chain select code into one update enable per chain.
// In test mode at most one enable is high, and none for an out-of-range code.
// In normal mode all enables are high.
module chain_enable_dec #(
    parameter int NUM_CHAINS = 3,
    parameter int SEL_W      = 2
) (
    input  logic                  test_mode,
    input  logic [SEL_W-1:0]      chain_sel,
    output logic [NUM_CHAINS-1:0] chain_en
);

    // One comparator per chain, overridden when not in test mode.
    always_comb begin
        for (int k = 0; k < NUM_CHAINS; k++) begin
            chain_en[k] = !test_mode || (int'(chain_sel) == k);
        end
    end

endmodule

// File: rtl/scan_segment.sv
// One scan chain of LEN cells. When enabled it either shifts (seg_sin enters
// bit 0, data moves toward bit LEN-1) or loads parallel data. When disabled
// it holds. Assumes LEN >= 1.
module scan_segment #(
    parameter int LEN = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           seg_en,
    input  logic           seg_shift,
    input  logic           seg_sin,
    input  logic [LEN-1:0] seg_d,
    output logic [LEN-1:0] seg_q
);

    logic [LEN-1:0] shifted;

    // Serial-shift view of the chain, valid for any LEN including 1.
    always_comb begin
        shifted    = seg_q << 1;
        shifted[0] = seg_sin;
    end

    // Chain register: reset, then hold, shift or parallel load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else if (seg_en) begin
            seg_q <= seg_shift ? shifted : seg_d;
        end
    end

endmodule

// File: rtl/scanout_select.sv
// Steers the tail bit of the addressed chain onto the serial output.
// A code that names no chain yields 0.
module scanout_select #(
    parameter int NUM_CHAINS = 3,
    parameter int SEL_W      = 2
) (
    input  logic [NUM_CHAINS-1:0] chain_tail,
    input  logic [SEL_W-1:0]      chain_sel,
    output logic                  scan_out
);

    // Compare-and-select multiplexer with a zero default.
    always_comb begin
        scan_out = 1'b0;
        for (int k = 0; k < NUM_CHAINS; k++) begin
            if (int'(chain_sel) == k) begin
                scan_out = chain_tail[k];
            end
        end
    end

endmodule

// File: rtl/core_next.sv
// Functional core. Next state of cell i is func_in[i] XOR the cell below it
// (cyclically). Output i is the XOR of cell i and the cell above it.
// Assumes NUM_FF >= 1.
module core_next #(
    parameter int NUM_FF = 10
) (
    input  logic [NUM_FF-1:0] cells,
    input  logic [NUM_FF-1:0] func_in,
    output logic [NUM_FF-1:0] nxt,
    output logic [NUM_FF-1:0] func_out
);

    // Next-state and primary-output logic, one bit per cell.
    always_comb begin
        for (int i = 0; i < NUM_FF; i++) begin
            nxt[i]      = func_in[i] ^ cells[(i + NUM_FF - 1) % NUM_FF];
            func_out[i] = cells[i] ^ cells[(i + 1) % NUM_FF];
        end
    end

endmodule

// File: rtl/solo_chain_scan.sv
// Scan wrapper in which only one chain updates per test cycle. Cells are
// grouped in index order into NUM_CHAINS chains of ceil(NUM_FF/NUM_CHAINS).
// Clock gating is modelled as a synchronous enable on one clock.
// Assumes every chain gets at least one cell.
module solo_chain_scan #(
    parameter int NUM_FF     = 10,
    parameter int NUM_CHAINS = 3,
    parameter int SEL_W      = solo_scan_pkg::sel_bits(NUM_CHAINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              scan_en,
    input  logic [SEL_W-1:0]  chain_sel,
    input  logic              scan_in,
    input  logic [NUM_FF-1:0] func_in,
    output logic              scan_out,
    output logic [NUM_FF-1:0] func_out
);

    localparam int CELLS = solo_scan_pkg::seg_cells(NUM_FF, NUM_CHAINS);

    logic [NUM_FF-1:0]     cells;
    logic [NUM_FF-1:0]     nxt;
    logic [NUM_CHAINS-1:0] chain_en;
    logic [NUM_CHAINS-1:0] chain_tail;
    logic                  do_shift;

    // Shift only applies in test mode; normal mode always loads next state.
    assign do_shift = test_mode && scan_en;

    chain_enable_dec #(
        .NUM_CHAINS (NUM_CHAINS),
        .SEL_W      (SEL_W)
    ) u_dec (
        .test_mode  (test_mode),
        .chain_sel  (chain_sel),
        .chain_en   (chain_en)
    );

    core_next #(
        .NUM_FF     (NUM_FF)
    ) u_core (
        .cells      (cells),
        .func_in    (func_in),
        .nxt        (nxt),
        .func_out   (func_out)
    );

    // One segment per chain over its slice of the cell vector.
    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
        localparam int LO  = k * CELLS;
        localparam int LEN = solo_scan_pkg::seg_len(NUM_FF, NUM_CHAINS, k);

        scan_segment #(
            .LEN        (LEN)
        ) u_seg (
            .clk        (clk),
            .rst_n      (rst_n),
            .seg_en     (chain_en[k]),
            .seg_shift  (do_shift),
            .seg_sin    (scan_in),
            .seg_d      (nxt[LO +: LEN]),
            .seg_q      (cells[LO +: LEN])
        );

        assign chain_tail[k] = cells[LO + LEN - 1];
    end

    scanout_select #(
        .NUM_CHAINS (NUM_CHAINS),
        .SEL_W      (SEL_W)
    ) u_sout (
        .chain_tail (chain_tail),
        .chain_sel  (chain_sel),
        .scan_out   (scan_out)
    );

endmodule

// File: rtl/solo_chain_scan_chk.sv
// Property checker for solo_chain_scan, attached by bind below. Relates the
// register state to the ports and to the core's next-state output.
module solo_chain_scan_chk #(
    parameter int NUM_FF     = 10,
    parameter int NUM_CHAINS = 3,
    parameter int SEL_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_mode,
    input logic              scan_en,
    input logic [SEL_W-1:0]  chain_sel,
    input logic              scan_in,
    input logic              scan_out,
    input logic [NUM_FF-1:0] cells,
    input logic [NUM_FF-1:0] nxt
);

    localparam int CELLS = solo_scan_pkg::seg_cells(NUM_FF, NUM_CHAINS);

    // Reset empties every cell.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> cells == '0);

    // Normal mode updates the whole state functionally.
    p_normal_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> cells == $past(nxt));

    // An unused code gives a silent output.
    p_nosel_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(chain_sel) >= NUM_CHAINS) |-> !scan_out);

    // An unused code freezes the state in test mode.
    p_nosel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && int'(chain_sel) >= NUM_CHAINS) |=> $stable(cells));

    for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chk
        localparam int LO  = k * CELLS;
        localparam int LEN = solo_scan_pkg::seg_len(NUM_FF, NUM_CHAINS, k);

        // Unselected chain holds in test mode.
        p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (test_mode && int'(chain_sel) != k) |=> $stable(cells[LO +: LEN]));

        // Head cell of the shifting chain takes the serial input.
        p_shift_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (test_mode && scan_en && int'(chain_sel) == k)
            |=> cells[LO] == $past(scan_in));

        // Body cells move one position up.
        if (LEN > 1) begin : g_body
            p_shift_body_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (test_mode && scan_en && int'(chain_sel) == k)
                |=> cells[LO + 1 +: LEN - 1] == $past(cells[LO +: LEN - 1]));
        end

        // Capturing chain loads the functional response.
        p_capture_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (test_mode && !scan_en && int'(chain_sel) == k)
            |=> cells[LO +: LEN] == $past(nxt[LO +: LEN]));

        // Serial output shows the addressed chain's tail.
        p_tail_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(chain_sel) == k) |-> scan_out == cells[LO + LEN - 1]);
    end

endmodule

bind solo_chain_scan solo_chain_scan_chk #(
    .NUM_FF     (NUM_FF),
    .NUM_CHAINS (NUM_CHAINS),
    .SEL_W      (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_mode  (test_mode),
    .scan_en    (scan_en),
    .chain_sel  (chain_sel),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .cells      (cells),
    .nxt        (nxt)
);

// File: tb/test_solo_chain_scan.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task applies one cycle of stimulus, advances a
// bit-accurate model and queues the expected outputs; the monitor pops and
// compares them shortly after each rising edge.
module test_solo_chain_scan;

    localparam int F  = 10;
    localparam int N  = 3;
    localparam int L  = 4;
    localparam int SW = 2;

    typedef struct {
        logic         sout;
        logic [F-1:0] po;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          test_mode;
    logic          scan_en;
    logic [SW-1:0] chain_sel;
    logic          scan_in;
    logic [F-1:0]  func_in;
    logic          scan_out;
    logic [F-1:0]  func_out;

    int            n_checks = 0;
    int            n_fail   = 0;
    bit            finished = 1'b0;
    logic [F-1:0]  mdl;
    exp_t          sb_q[$];

    solo_chain_scan #(
        .NUM_FF     (F),
        .NUM_CHAINS (N),
        .SEL_W      (SW)
    ) i_solo_chain_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_mode  (test_mode),
        .scan_en    (scan_en),
        .chain_sel  (chain_sel),
        .scan_in    (scan_in),
        .func_in    (func_in),
        .scan_out   (scan_out),
        .func_out   (func_out)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Highest cell index of chain k (R8 partition).
    function automatic int tail_of(input int k);
        return ((k * L + L) < F) ? (k * L + L - 1) : (F - 1);
    endfunction

    // Model of one clock edge from R2..R5 and R7.
    function automatic logic [F-1:0] ref_next(input logic [F-1:0] m, input logic tm,
                                              input logic se, input int sel,
                                              input logic si, input logic [F-1:0] fin);
        logic [F-1:0] r;
        r = m;
        if (!tm) begin
            for (int i = 0; i < F; i++) r[i] = fin[i] ^ m[(i + F - 1) % F];
        end else if (sel < N) begin
            for (int i = sel * L; i <= tail_of(sel); i++) begin
                if (se) r[i] = (i == sel * L) ? si : m[i - 1];
                else    r[i] = fin[i] ^ m[(i + F - 1) % F];
            end
        end
        return r;
    endfunction

    // Expected serial output (R6, R7).
    function automatic logic ref_sout(input logic [F-1:0] m, input int sel);
        return (sel < N) ? m[tail_of(sel)] : 1'b0;
    endfunction

    // Expected primary outputs (R9).
    function automatic logic [F-1:0] ref_po(input logic [F-1:0] m);
        logic [F-1:0] r;
        for (int i = 0; i < F; i++) r[i] = m[i] ^ m[(i + 1) % F];
        return r;
    endfunction

    // Direct check helper used outside the scoreboard.
    task automatic check_now(input string tag, input logic sout_e, input logic [F-1:0] po_e);
        n_checks++;
        if (scan_out !== sout_e || func_out !== po_e) begin
            n_fail++;
            $display("FAIL %s: scan_out=%b func_out=%b expected scan_out=%b func_out=%b",
                     tag, scan_out, func_out, sout_e, po_e);
        end
    endtask

    // Driver: one cycle of stimulus, model update, expected item queued.
    task automatic step(input logic tm, input logic se, input int sel,
                        input logic si, input logic [F-1:0] fin, input string tag);
        logic [F-1:0] m_next;
        exp_t         e;
        @(negedge clk);
        test_mode = tm;
        scan_en   = se;
        chain_sel = SW'(sel);
        scan_in   = si;
        func_in   = fin;
        m_next    = ref_next(mdl, tm, se, sel, si, fin);
        @(posedge clk);
        mdl = m_next;
        #1;
        e.sout = ref_sout(mdl, sel);
        e.po   = ref_po(mdl);
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Synchronous reset for a few cycles (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        test_mode = 1'b0;
        scan_en   = 1'b0;
        chain_sel = '0;
        scan_in   = 1'b0;
        func_in   = '0;
        repeat (3) @(posedge clk);
        mdl = '0;
        @(negedge clk);
        rst_n = 1'b1;
        check_now("R1", 1'b0, '0);
    endtask

    // Monitor: compare queued expectations after each rising edge.
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (scan_out !== e.sout || func_out !== e.po) begin
                n_fail++;
                $display("FAIL %s: scan_out=%b func_out=%b expected scan_out=%b func_out=%b",
                         e.tag, scan_out, func_out, e.sout, e.po);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(150000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    // Stimulus.
    initial begin
        mdl = '0;
        do_reset();

        // R2 and R9: normal mode, scan_en and chain_sel varied but ignored.
        step(1'b0, 1'b1, 0, 1'b1, 10'b1011001110, "R2");
        step(1'b0, 1'b0, 2, 1'b0, 10'b0100110001, "R2");
        step(1'b0, 1'b1, 3, 1'b1, 10'b1111100000, "R9");
        step(1'b0, 1'b0, 1, 1'b0, 10'b0000011111, "R9");

        // R3: load each chain serially with a distinct pattern.
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j < L; j++) step(1'b1, 1'b1, k, 1'((k + j) & 1) ^ 1'(j == 2), '0, "R3");
        end

        // R4: capture on chain 1 only, then unload it.
        step(1'b1, 1'b0, 1, 1'b0, 10'b1010101010, "R4");
        for (int j = 0; j < L; j++) step(1'b1, 1'b1, 1, 1'b0, '0, "R4");

        // R5: capture on chain 2, then unload chains 0 and 1 to confirm they held.
        step(1'b1, 1'b0, 2, 1'b0, 10'b1100110011, "R5");
        for (int j = 0; j < L; j++) step(1'b1, 1'b1, 0, 1'b1, '0, "R5");
        for (int j = 0; j < L; j++) step(1'b1, 1'b1, 1, 1'b0, '1, "R5");

        // R8: the short final chain shows a new bit at its tail after two shifts.
        step(1'b1, 1'b1, 2, 1'b1, '0, "R8");
        step(1'b1, 1'b1, 2, 1'b0, '0, "R8");
        step(1'b1, 1'b1, 2, 1'b0, '0, "R8");

        // R7: out-of-range code, shift and capture both leave the state alone.
        step(1'b1, 1'b1, 3, 1'b1, 10'b1111111111, "R7");
        step(1'b1, 1'b0, 3, 1'b1, 10'b1010011100, "R7");
        step(1'b0, 1'b0, 3, 1'b0, 10'b0011100101, "R7");

        // R6: long mixed sequence.
        for (int t = 0; t < 600; t++) begin
            int sel;
            sel = int'($urandom_range(0, 3));
            step(1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 1)), sel,
                 1'($urandom_range(0, 1)), F'($urandom), "R6");
        end

        // R1: reset from an arbitrary state.
        do_reset();
        step(1'b1, 1'b1, 0, 1'b0, '0, "R1");

        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule